// File: doc/BRIEF.md
# Converter Conversion and Calibration Sequencer

This block is the digital timing core of a four-channel, 12-bit successive-approximation converter that calibrates itself. A host starts a conversion by pulsing an active-low write strobe while chip select is low, choosing one of four channels on two address lines. Optionally, a sample-control pin can end sampling and launch the decision phase directly. Each conversion is a counted sample phase followed by one bit decision per clock, from MSB to LSB. The comparator is a digital input. The block offers a trial code for it to compare against and collects the decisions into a 12-bit result.

Calibration is a fixed-length counted phase. It runs on its own after a long supply-settling wait that follows reset or a power-fail indication. It can also be requested by a rising edge on the calibration pin or by a control-register write. Every calibration ends with an automatic conversion, so valid data is present when the block goes idle. Calibration always wins: it cuts off a conversion in flight and locks out new convert requests until it is over.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is high, `rdy_o`, `cal_o` and `valid_o` are low and `result_o` is zero.
- R2: After reset is released, calibration (`cal_o` high) begins exactly SETTLE_CYC (42425) clock edges later. Until then the block is busy and ignores requests.
- R3: Calibration keeps `cal_o` high for CAL_CYC (168) cycles and is followed directly by a 17-cycle conversion of the last accepted channel (channel 0 after reset). The busy time is 185 cycles, and the result is delivered with one `valid_o` pulse.
- R4: A rising edge on `wr_n_i` while `cs_n_i` is low starts a conversion. `rdy_o` is low for exactly 17 cycles, of which `sample_o` is high for the first 5. `rdy_o` rises in the same cycle as a single `valid_o` pulse.
- R5: The decision phase keeps each trial bit when `cmp_i` is 1 and clears it otherwise, MSB first. With a comparator that reports `trial_o <= level`, `result_o` equals the level.
- R6: The channel address (binary, 0 to 3) is taken at the accepted write edge and shown on `chan_o` during the conversion.
- R7: A write edge while `cs_n_i` is high starts nothing.
- R8: Calibration is requested by the rising edge of a low pulse on `cal_n_i`, or by a control write with bit 1 set. Bit 1 does not stay set.
- R9: A calibration request aborts a conversion in progress. The aborted conversion produces no `valid_o` pulse.
- R10: Convert requests during calibration are ignored. No extra conversion follows, and the channel is not changed.
- R11: A control write stores bit 2 as the external-sample mode. In that mode `sample_o` is high while idle, and a rising edge on `cal_n_i` starts the 12-cycle decision phase directly, without calibration.
- R12: While `pwr_fail_i` is high the block is busy. After it falls, calibration begins exactly SETTLE_CYC edges later.
- R13: When a calibration request and a convert request arrive in the same cycle, calibration wins and the convert request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fail_i | input | 1 | Power-fail indication; restarts settling |
| wr_n_i | input | 1 | Active-low write strobe; rising edge requests a conversion |
| cs_n_i | input | 1 | Active-low chip select |
| chan_i | input | 2 | Channel address |
| cal_n_i | input | 1 | Calibration / sample-control pin, active low |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 8 | Control write data: bit 1 calibrate, bit 2 external-sample mode |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| rdy_o | output | 1 | High only when idle (inverse of busy) |
| cal_o | output | 1 | Calibration phase active |
| sample_o | output | 1 | Input being sampled |
| chan_o | output | 2 | Channel being converted |
| trial_o | output | 12 | Trial code for the comparator during decisions |
| result_o | output | 12 | Last conversion result |
| valid_o | output | 1 | One-cycle pulse when `result_o` is loaded |

## Verification
The hardest state to reach from the ports is a calibration request landing in the same cycle as a convert request. Both pins pass through the same two-stage synchronizer. The stimulus therefore releases `cal_n_i` and `wr_n_i` on the same falling clock edge, so their rising edges are detected together. Aborting a conversion mid-flight is done by issuing a control write a few cycles after a write strobe. Ignoring a request is shown by strobing a different channel during calibration: the delivered result still matches the old channel's level, and no second `valid_o` follows. The constrained-random part draws channels and comparator levels from a seeded generator, and the directed part covers the code extremes 0 and 4095.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE = 3'd0,
    ST_IDLE   = 3'd1,
    ST_CAL    = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_CONV   = 3'd4
  } seq_st_e;

  // control word bit positions (decoded by the top)
  localparam int CTRL_CAL_BIT = 1;
  localparam int CTRL_EXT_BIT = 2;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int               W        = 5,
  parameter int               EDGE_W   = 2,
  parameter int               STAGES   = 2,
  parameter logic [W-1:0]     RST_VAL  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      async_i,
  output logic [W-1:EDGE_W] level_o,
  output logic [EDGE_W-1:0] rise_o
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [EDGE_W-1:0]        prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q  <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL[EDGE_W-1:0];
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
      prev_q <= stg_q[STAGES-1][EDGE_W-1:0];
    end
  end

  assign level_o = stg_q[STAGES-1][W-1:EDGE_W];
  assign rise_o  = stg_q[STAGES-1][EDGE_W-1:0] & ~prev_q;

  // an edge is reported for one cycle only (trigger inputs, R8)
  assert_rise_single_R8: assert property (@(posedge clk) disable iff (rst)
    (rise_o & $past(rise_o)) == '0);

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
  parameter int DATA_W = 12,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] word_o
);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_d;
  logic [DATA_W-1:0] probe;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign probe[b] = (idx_i == IDX_W'(b));
      assign acc_d[b] = probe[b] ? cmp_i : acc_q[b];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !step_i) acc_q <= '0;
    else                acc_q <= acc_d;
  end

  assign trial_o = step_i ? (acc_q | probe) : '0;
  assign word_o  = acc_d;

  // a decision made in one cycle is kept in the next (R5)
  assert_decision_kept_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(step_i) && step_i) |-> (acc_q[$past(idx_i)] == $past(cmp_i)));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int CH_W       = 2,
  parameter int SAMPLE_CYC = 5,
  parameter int CAL_CYC    = 168,
  parameter int SETTLE_CYC = 42425,
  localparam int IDX_W     = $clog2(DATA_W),
  localparam int MAX_CYC   = (SETTLE_CYC > CAL_CYC) ? SETTLE_CYC : CAL_CYC,
  localparam int CNT_W     = $clog2(MAX_CYC) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_fail_i,
  input  logic             cal_req_i,
  input  logic             conv_wr_i,
  input  logic             conv_ext_i,
  input  logic [CH_W-1:0]  chan_i,
  output seq_st_e          st_o,
  output logic             step_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CH_W-1:0]  chan_o
);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  chan_q, chan_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + 1'b1;
    chan_d = chan_q;
    if (pwr_fail_i) begin
      st_d  = ST_SETTLE;
      cnt_d = '0;
    end else if (st_q == ST_SETTLE) begin
      if (cnt_q == CNT_W'(SETTLE_CYC - 1)) begin
        st_d  = ST_CAL;
        cnt_d = '0;
      end
    end else if (cal_req_i) begin
      st_d  = ST_CAL;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (conv_wr_i) begin
            st_d   = ST_SAMPLE;
            chan_d = chan_i;
          end else if (conv_ext_i) begin
            st_d = ST_CONV;
          end
        end
        ST_CAL: if (cnt_q == CNT_W'(CAL_CYC - 1)) begin
          st_d  = ST_SAMPLE;
          cnt_d = '0;
        end
        ST_SAMPLE: if (cnt_q == CNT_W'(SAMPLE_CYC - 1)) begin
          st_d  = ST_CONV;
          cnt_d = '0;
        end
        ST_CONV: if (cnt_q == CNT_W'(DATA_W - 1)) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
        default: begin
          st_d  = ST_SETTLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_SETTLE;
      cnt_q  <= '0;
      chan_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      chan_q <= chan_d;
    end
  end

  assign st_o   = st_q;
  assign step_o = (st_q == ST_CONV);
  assign last_o = step_o && (cnt_q == CNT_W'(DATA_W - 1));
  assign idx_o  = IDX_W'(DATA_W - 1) - cnt_q[IDX_W-1:0];
  assign chan_o = chan_q;

  // calibration hands over to the sample phase unless preempted (R3)
  assert_cal_to_sample_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == ST_CAL && st_q != ST_CAL && !$past(pwr_fail_i))
      |-> st_q == ST_SAMPLE);

  // decisions start only after the full sample window (R4)
  assert_sample_len_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == ST_SAMPLE && st_q == ST_CONV)
      |-> $past(cnt_q) == CNT_W'(SAMPLE_CYC - 1));

  // channel stays put while calibrating (R10)
  assert_chan_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CAL && conv_wr_i && !pwr_fail_i) |=> $stable(chan_q));

  // calibration wins over anything but settling / power fail (R9, R13)
  assert_cal_wins_R13: assert property (@(posedge clk) disable iff (rst)
    (cal_req_i && !pwr_fail_i && st_q != ST_SETTLE) |=> st_q == ST_CAL);

  // power fail restarts the settling wait (R12)
  assert_pwr_restart_R12: assert property (@(posedge clk) disable iff (rst)
    pwr_fail_i |=> (st_q == ST_SETTLE && cnt_q == '0));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CH_W        = 2,
  parameter int SAMPLE_CYC  = 5,
  parameter int CAL_CYC     = 168,
  parameter int SETTLE_CYC  = 42425,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_W      = 8,
  localparam int IDX_W      = $clog2(DATA_W),
  localparam int PIN_W      = CH_W + 3,
  localparam int EDGE_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_fail_i,
  input  logic              wr_n_i,
  input  logic              cs_n_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              cal_n_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              cmp_i,
  output logic              rdy_o,
  output logic              cal_o,
  output logic              sample_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);

  // pin order: strobes in the low bits so they get edge detectors
  logic [PIN_W-1:EDGE_W] pin_lvl;
  logic [EDGE_W-1:0]     pin_rise;

  adc_seq_sync #(
    .W       (PIN_W),
    .EDGE_W  (EDGE_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({PIN_W{1'b1}})
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({chan_i, cs_n_i, wr_n_i, cal_n_i}),
    .level_o (pin_lvl),
    .rise_o  (pin_rise)
  );

  logic            cal_rise, wr_rise, cs_n_s;
  logic [CH_W-1:0] chan_s;
  assign cal_rise = pin_rise[0];
  assign wr_rise  = pin_rise[1];
  assign cs_n_s   = pin_lvl[2];
  assign chan_s   = pin_lvl[PIN_W-1:3];

  logic ext_q;
  always_ff @(posedge clk) begin
    if (rst)            ext_q <= 1'b0;
    else if (ctrl_we_i) ext_q <= ctrl_wdata_i[CTRL_EXT_BIT];
  end

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{ctrl_wdata_i[CTRL_W-1:CTRL_EXT_BIT+1],
                              ctrl_wdata_i[CTRL_CAL_BIT-1:0]};

  logic cal_req, conv_wr, conv_ext;
  assign cal_req  = (ctrl_we_i & ctrl_wdata_i[CTRL_CAL_BIT]) | (cal_rise & ~ext_q);
  assign conv_wr  = wr_rise & ~cs_n_s;
  assign conv_ext = cal_rise & ext_q;

  seq_st_e          st;
  logic             step, last;
  logic [IDX_W-1:0] idx;

  adc_seq_fsm #(
    .DATA_W     (DATA_W),
    .CH_W       (CH_W),
    .SAMPLE_CYC (SAMPLE_CYC),
    .CAL_CYC    (CAL_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .pwr_fail_i (pwr_fail_i),
    .cal_req_i  (cal_req),
    .conv_wr_i  (conv_wr),
    .conv_ext_i (conv_ext),
    .chan_i     (chan_s),
    .st_o       (st),
    .step_o     (step),
    .last_o     (last),
    .idx_o      (idx),
    .chan_o     (chan_o)
  );

  logic [DATA_W-1:0] word;

  adc_seq_sar #(
    .DATA_W (DATA_W)
  ) u_sar (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step),
    .idx_i   (idx),
    .cmp_i   (cmp_i),
    .trial_o (trial_o),
    .word_o  (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= last && !cal_req && !pwr_fail_i;
      if (last && !cal_req && !pwr_fail_i) result_o <= word;
    end
  end

  assign rdy_o    = (st == ST_IDLE);
  assign cal_o    = (st == ST_CAL);
  assign sample_o = (st == ST_SAMPLE) || (st == ST_IDLE && ext_q);

  // result only moves together with the valid pulse (R5)
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(result_o));

  // external-sample edge goes straight to decisions (R11)
  assert_ext_direct_R11: assert property (@(posedge clk) disable iff (rst)
    (conv_ext && st == ST_IDLE && !cal_req && !pwr_fail_i) |=> (step && !cal_o));

  // no result while calibration runs (R9)
  assert_no_valid_in_cal_R9: assert property (@(posedge clk) disable iff (rst)
    cal_o |-> !valid_o);

endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;

  localparam int SETTLE = 42425;
  localparam int CALN   = 168;
  localparam int CONVN  = 17;
  localparam int DECN   = 12;
  localparam int SAMPN  = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_fail = 1'b0;
  logic        wr_n = 1'b1, cs_n = 1'b1, cal_n = 1'b1;
  logic [1:0]  chan = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic        cmp;
  logic        rdy, cal, sample, valid;
  logic [1:0]  chan_o;
  logic [11:0] trial, result;
  logic [11:0] ana [4];

  always #2 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .pwr_fail_i(pwr_fail), .wr_n_i(wr_n), .cs_n_i(cs_n),
    .chan_i(chan), .cal_n_i(cal_n), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .cmp_i(cmp), .rdy_o(rdy), .cal_o(cal), .sample_o(sample), .chan_o(chan_o),
    .trial_o(trial), .result_o(result), .valid_o(valid)
  );

  // comparator model: input level at or above the trial code
  assign cmp = (trial <= ana[chan_o]);

  int total = 0, bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; samples there and on each following one
  task automatic measure(output int n, output int ncal, output int nsamp, output int nv);
    n = 0; ncal = 0; nsamp = 0; nv = 0;
    for (int g = 0; g < 2000; g++) begin
      nv += int'(valid);
      if (!rdy) begin
        n++; ncal += int'(cal); nsamp += int'(sample);
      end else if (n > 0) break;
      @(negedge clk);
    end
  endtask

  task automatic wr_pulse(input logic [1:0] ch, input logic csn);
    @(negedge clk);
    chan = ch; cs_n = csn; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic cal_pulse();
    @(negedge clk);
    cal_n = 1'b0;
    repeat (2) @(negedge clk);
    cal_n = 1'b1;
  endtask

  task automatic ctrl_write(input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  function automatic int settle_expect();
    return SETTLE;
  endfunction

  task automatic count_to_cal(output int n);
    n = 0;
    for (int g = 0; g < SETTLE + 100; g++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (cal) break;
    end
  endtask

  initial begin
    int n, nc, ns, nv, lastch, quiet_v, quiet_busy;
    void'($urandom(32'd20240611));
    ana[0] = 12'd0; ana[1] = 12'hFFF; ana[2] = 12'h800; ana[3] = 12'h7FF;

    // R1: reset state
    repeat (5) @(negedge clk);
    chk("R1 rdy", int'(rdy), 0);
    chk("R1 cal", int'(cal), 0);
    chk("R1 valid", int'(valid), 0);
    chk("R1 result", int'(result), 0);
    ana[0] = 12'h5A3;
    rst = 1'b0;

    // R2: settle wait, then R3: calibration plus appended conversion
    count_to_cal(n);
    chk("R2 settle edges", n, settle_expect());
    measure(n, nc, ns, nv);
    chk("R3 busy", n, CALN + CONVN);
    chk("R3 cal cycles", nc, CALN);
    chk("R3 sample cycles", ns, SAMPN);
    chk("R3 valid pulses", nv, 1);
    chk("R3 result ch0", int'(result), int'(ana[0]));
    lastch = 0;

    // R4/R5/R6: directed extremes on each channel
    ana[0] = 12'd0;
    for (int c = 0; c < 4; c++) begin
      wr_pulse(2'(c), 1'b0);
      measure(n, nc, ns, nv);
      cs_n = 1'b1;
      chk("R4 busy", n, CONVN);
      chk("R4 sample", ns, SAMPN);
      chk("R4 valid", nv, 1);
      chk("R5 result", int'(result), int'(ana[c]));
      chk("R6 chan", int'(chan_o), c);
    end
    lastch = 3;

    // R5/R6: constrained random levels and channels
    for (int k = 0; k < 24; k++) begin
      int c;
      c = int'($urandom_range(3, 0));
      ana[c] = 12'($urandom_range(4095, 0));
      wr_pulse(2'(c), 1'b0);
      measure(n, nc, ns, nv);
      cs_n = 1'b1;
      chk("R4 rnd busy", n, CONVN);
      chk("R5 rnd result", int'(result), int'(ana[c]));
      chk("R6 rnd chan", int'(chan_o), c);
      lastch = c;
    end

    // R7: chip select high blocks the strobe
    wr_pulse(2'd0, 1'b1);
    quiet_v = 0; quiet_busy = 0;
    for (int g = 0; g < 30; g++) begin
      @(negedge clk);
      quiet_v += int'(valid); quiet_busy += int'(!rdy);
    end
    chk("R7 no busy", quiet_busy, 0);
    chk("R7 no valid", quiet_v, 0);

    // R8: calibration from the control register, bit 1
    ctrl_write(8'h02);
    measure(n, nc, ns, nv);
    chk("R8 reg busy", n, CALN + CONVN);
    chk("R8 reg cal", nc, CALN);
    chk("R8 reg result", int'(result), int'(ana[lastch]));

    // R8: calibration from the pin
    cal_pulse();
    measure(n, nc, ns, nv);
    chk("R8 pin cal", nc, CALN);
    chk("R8 pin busy", n, CALN + CONVN);

    // R9: calibration aborts a running conversion
    ana[1] = 12'h3C5;
    wr_pulse(2'd1, 1'b0);
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    ctrl_write(8'h02);
    measure(n, nc, ns, nv);
    chk("R9 busy", n, CALN + CONVN);
    chk("R9 single valid", nv, 1);
    chk("R9 result", int'(result), int'(ana[1]));

    // R10: convert request during calibration is ignored
    ana[3] = 12'h111;
    ctrl_write(8'h02);
    repeat (20) @(negedge clk);
    wr_pulse(2'd3, 1'b0);
    measure(n, nc, ns, nv);
    cs_n = 1'b1;
    chk("R10 valid", nv, 1);
    chk("R10 result old chan", int'(result), int'(ana[1]));
    quiet_v = 0; quiet_busy = 0;
    for (int g = 0; g < 40; g++) begin
      @(negedge clk);
      quiet_v += int'(valid); quiet_busy += int'(!rdy);
    end
    chk("R10 no extra conv", quiet_busy + quiet_v, 0);

    // R13: coincident calibration and convert edges
    @(negedge clk);
    chan = 2'd2; cs_n = 1'b0; wr_n = 1'b0; cal_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1; cal_n = 1'b1;
    measure(n, nc, ns, nv);
    cs_n = 1'b1;
    chk("R13 cal cycles", nc, CALN);
    chk("R13 busy", n, CALN + CONVN);
    chk("R13 chan kept", int'(result), int'(ana[1]));

    // R11: external sample mode
    ctrl_write(8'h04);
    @(negedge clk);
    chk("R11 idle sample", int'(sample), 1);
    ana[1] = 12'hA5A;
    cal_pulse();
    measure(n, nc, ns, nv);
    chk("R11 busy", n, DECN);
    chk("R11 no cal", nc, 0);
    chk("R11 no sample phase", ns, 0);
    chk("R11 result", int'(result), int'(ana[1]));
    ctrl_write(8'h00);
    @(negedge clk);
    chk("R11 mode off", int'(sample), 0);

    // R12: power fail restarts settling
    @(negedge clk);
    pwr_fail = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 busy in fail", int'(rdy), 0);
    pwr_fail = 1'b0;
    count_to_cal(n);
    chk("R12 settle edges", n, settle_expect());
    measure(n, nc, ns, nv);
    chk("R12 recal busy", n, CALN + CONVN);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule